// File: doc/BRIEF.md
# PHY Management Interrupt Controller

This block drives the active-low interrupt line of an Ethernet transceiver's management interface. It watches two status inputs: energy detected on the line, and auto-negotiation complete. A rising edge on either input sets a flag bit for that source. The interrupt line goes low while any flagged source is also enabled in the mask register.

Software reaches three registers through a simple read/write port: the mask register, the flag register and a mode register. Reads are combinational. The flag register is read-only, and reading it clears the flags at the next clock edge.

Two release modes exist:
- **Primary mode** is the default and is restored by every reset. A flag also clears when its status input falls.
- **Alternative mode** ignores falling status inputs. The line then stays asserted until software reads the flags.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset, irq_n is 1, and the mask (address 30), flag (address 29) and mode (address 17) registers all read 0. Every reset, including one applied mid-run, returns the block to primary mode.
- R2: A rising edge on a status input sets that source's flag bit one clock after the edge is sampled. Energy is ev_status[1] and sets flag bit 7. Auto-negotiation is ev_status[0] and sets flag bit 6. A flag bit is set regardless of the mask, and a status held high sets it only once.
- R3: irq_n is 0 exactly when some flag bit is set and the mask bit at the same position (7 or 6) is also set.
- R4: In primary mode (mode bit 6 of address 17 is 0), a falling status input clears that source's flag.
- R5: A read of address 29 returns the current flag bits and clears them at the following clock edge.
- R6: In alternative mode (mode bit 6 is 1), a falling status input leaves the flag set until address 29 is read.
- R7: When a rising edge coincides with a read of address 29, the new event wins and its flag stays set after the read.
- R8: Only bits 7:6 of the mask register and bit 6 of the mode register are writable, and all other bits read 0. Writes to the flag register have no effect. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_status | input | 2 | Status inputs: [1] energy detected, [0] auto-negotiation complete |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 29 clears the flags |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
Directed sequences cover the following cases, each in both modes where the mode matters:
- A rise with the source masked off shows that flags latch independently of the mask.
- A status held high shows that each edge sets its flag once.
- A fall followed by a read separates the primary release from the alternative release.
- A rise in the same cycle as a flag read pins down which of the two wins.

A long random run then mixes status toggles, mask and mode writes, and reads at random addresses. A bench model predicts every read and the interrupt line each cycle, which catches wrong precedence between setting and clearing.

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl #(
  parameter int AW        = 5,
  parameter int DW        = 16,
  parameter int NSRC      = 2,
  parameter int MODE_ADDR = 17,
  parameter int FLAG_ADDR = 29,
  parameter int MASK_ADDR = 30,
  parameter int FIELD_LSB = 6,
  parameter int MODE_BIT  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev_status,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_n
);
  localparam logic [AW-1:0] A_MODE = AW'(MODE_ADDR);
  localparam logic [AW-1:0] A_FLAG = AW'(FLAG_ADDR);
  localparam logic [AW-1:0] A_MASK = AW'(MASK_ADDR);

  logic [NSRC-1:0] prev, flag, mask;
  logic            alt_mode;

  wire [NSRC-1:0] rise    = ev_status & ~prev;
  wire [NSRC-1:0] fall    = ~ev_status & prev;
  wire            rd_flag = reg_rd && (reg_addr == A_FLAG);
  wire [NSRC-1:0] clr     = {NSRC{rd_flag}} | (alt_mode ? '0 : fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= '0;
      flag     <= '0;
      mask     <= '0;
      alt_mode <= 1'b0;
    end else begin
      prev <= ev_status;
      flag <= rise | (flag & ~clr);
      if (reg_wr && reg_addr == A_MASK) mask <= reg_wdata[FIELD_LSB +: NSRC];
      if (reg_wr && reg_addr == A_MODE) alt_mode <= reg_wdata[MODE_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_FLAG:  reg_rdata[FIELD_LSB +: NSRC] = flag;
      A_MASK:  reg_rdata[FIELD_LSB +: NSRC] = mask;
      A_MODE:  reg_rdata[MODE_BIT] = alt_mode;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_n = ~|(flag & mask);

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_status[i] && !prev[i]) |=> flag[i]);
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_flag && !(ev_status[i] && !prev[i])) |=> !flag[i]);
    a_r4_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!alt_mode && prev[i] && !ev_status[i]) |=> !flag[i]);
    a_r6_alt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_mode && flag[i] && !rd_flag) |=> flag[i]);
    a_r3_line_low: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && mask[i] && !rd_flag && !(!alt_mode && prev[i] && !ev_status[i])
       && !(reg_wr && reg_addr == A_MASK)) |=> !irq_n);
  end
endmodule

// File: tb/phy_irq_ctrl_test.sv
module phy_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ev_status = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_n;

  int errors = 0, checks = 0;
  logic [1:0] ef, em, ep;
  logic       emode;

  phy_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ev_status(ev_status), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rexp(input logic [4:0] a);
    case (a)
      5'd29:   return 16'(ef) << 6;
      5'd30:   return 16'(em) << 6;
      5'd17:   return 16'(emode) << 6;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic irq_exp();
    return !(|(ef & em));
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    ef = '0; em = '0; ep = '0; emode = 1'b0;
  endtask

  task automatic cyc(input string tag, input logic [1:0] st, input logic wr,
                     input logic rd, input logic [4:0] a, input logic [15:0] wd);
    logic [1:0] rise, fall, clr;
    @(negedge clk);
    ev_status = st; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    #1;
    if (rd) check(tag, reg_rdata, rexp(a));
    rise = st & ~ep;
    fall = ~st & ep;
    clr  = {2{rd && a == 5'd29}} | (emode ? 2'b00 : fall);
    @(posedge clk);
    #1;
    ef = rise | (ef & ~clr);
    if (wr && a == 5'd30) em = wd[7:6];
    if (wr && a == 5'd17) emode = wd[6];
    ep = st;
    check({tag, " irq_n"}, 16'(irq_n), 16'(irq_exp()));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; ev_status = '0;
    model_reset();
    #(CLK_PERIOD*2);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    // R1 reset state
    #1 check("R1 irq_n", 16'(irq_n), 16'd1);
    cyc("R1", 2'b00, 0, 1, 5'd30, 0);
    cyc("R1", 2'b00, 0, 1, 5'd17, 0);
    cyc("R1", 2'b00, 0, 1, 5'd29, 0);
    // R2 flag latches with mask off, once per edge
    cyc("R2", 2'b10, 0, 0, 5'd0, 0);
    cyc("R2", 2'b10, 0, 1, 5'd29, 0);
    cyc("R2", 2'b10, 0, 0, 5'd0, 0);
    cyc("R2", 2'b10, 0, 1, 5'd29, 0);
    // R8 reserved bits and flag write ignored
    cyc("R8", 2'b10, 1, 0, 5'd30, 16'hFFFF);
    cyc("R8", 2'b10, 0, 1, 5'd30, 0);
    cyc("R8", 2'b10, 1, 0, 5'd29, 16'hFFFF);
    cyc("R8", 2'b10, 0, 1, 5'd29, 0);
    cyc("R8", 2'b10, 0, 1, 5'd5, 0);
    // R3 and R4: auto-neg rise asserts, fall releases in primary mode
    cyc("R3", 2'b11, 0, 0, 5'd0, 0);
    cyc("R3", 2'b11, 0, 0, 5'd0, 0);
    cyc("R4", 2'b10, 0, 0, 5'd0, 0);
    cyc("R4", 2'b10, 0, 1, 5'd29, 0);
    // R6 alternative mode holds through a fall
    cyc("R6", 2'b10, 1, 0, 5'd17, 16'h0040);
    cyc("R6", 2'b10, 0, 1, 5'd17, 0);
    cyc("R6", 2'b11, 0, 0, 5'd0, 0);
    cyc("R6", 2'b10, 0, 0, 5'd0, 0);
    cyc("R6", 2'b10, 0, 0, 5'd0, 0);
    cyc("R6", 2'b00, 0, 1, 5'd29, 0);
    cyc("R6", 2'b00, 0, 1, 5'd29, 0);
    // R7 rise coincident with read
    cyc("R7", 2'b01, 0, 1, 5'd29, 0);
    cyc("R7", 2'b01, 0, 1, 5'd29, 0);
    // R5 read clears
    cyc("R5", 2'b00, 0, 0, 5'd0, 0);
    cyc("R5", 2'b11, 0, 0, 5'd0, 0);
    cyc("R5", 2'b11, 0, 1, 5'd29, 0);
    cyc("R5", 2'b11, 0, 1, 5'd29, 0);
    // R1 mid-run reset returns to primary mode
    do_reset();
    cyc("R1", 2'b00, 0, 1, 5'd17, 0);
    cyc("R1", 2'b00, 0, 1, 5'd30, 0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] a;
      logic [1:0] st;
      logic wr, rd;
      int sel;
      sel = $urandom_range(0, 4);
      a = (sel == 0) ? 5'd17 : (sel == 1) ? 5'd30 : (sel == 4) ? 5'($urandom) : 5'd29;
      st = ($urandom_range(0, 3) == 0) ? 2'($urandom) : ev_status;
      wr = ($urandom_range(0, 5) == 0);
      rd = ($urandom_range(0, 3) == 0);
      cyc((a == 5'd29) ? "R5" : (a == 5'd17) ? "R6" : "R8", st, wr, rd, a, 16'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule